// File: doc/BRIEF.md
# Multi-Cycle Reorder Buffer Squash Walker

This block holds the reorder-buffer entry queues of several hardware threads and undoes a mispredicted path in one of them over several cycles. A squash request names a thread and a boundary sequence number. Starting from that thread's youngest entry, the walker moves toward the oldest entry. It flags every entry it passes as both squashed and ready, so that retirement can drain those entries without executing them. A fixed number of entries per thread per cycle limits the write bandwidth into the flag array.

The walk of a thread ends at the first entry whose sequence number is not above the boundary, or right after it has flagged the thread's oldest entry. A busy indicator for each thread (shown inverted as a done bit) lets the commit stage wait until that thread is clean. A pulse tells the global tail tracker to recompute whenever a thread's youngest entry was flagged. Each thread has its own walk state, so walks on different threads run at the same time. A fresh request for a thread that is already walking restarts that walk from the youngest entry with the new boundary. Allocation appends entries at a thread's young end. Retirement removes the thread's oldest entry and shows it at the head outputs.

Top module: `rob_squash_walker`

## Requirements
- R1: A squash request for a thread with no entries flags nothing, gives no tail pulse, and leaves done at 1 in the next cycle.
- R2: A squash request for a non-empty thread starts its walk in the same cycle at the thread's youngest entry. If the walk does not end in that cycle, the thread's done output reads 0 from the next cycle.
- R3: Within one cycle, at most SQ_WIDTH entries of a single thread are flagged.
- R4: A flagged entry has both its squashed and its ready flag set. Entries whose sequence number is at or below the boundary stay unflagged (both flags 0).
- R5: When the walk reaches the thread's oldest entry, that entry is flagged and the walk ends.
- R6: The walk ends as soon as the entry it is looking at has a sequence number at or below the boundary. This includes the entry just past the last one flagged in a cycle. Done reads 1 from the cycle after the walk ends.
- R7: The tail pulse for a thread is 1, combinationally, in exactly the cycles in which that thread's youngest entry is flagged.
- R8: A new request for a thread that is already walking restarts that walk from its youngest entry with the new boundary. Entries the old walk did not yet reach are left unflagged.
- R9: Walks on different threads progress independently in the same cycles.
- R10: After reset every thread is empty, every done bit is 1 and every tail pulse is 0.
- R11: Allocation appends an entry with both flags 0. Retirement removes the oldest entry. The count and head outputs show the oldest entry's sequence number and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alloc_valid | input | 1 | Append one entry |
| alloc_tid | input | TID_W | Thread that receives the entry |
| alloc_seq | input | SEQ_W | Sequence number of the new entry |
| retire_valid | input | 1 | Remove the oldest entry of a thread |
| retire_tid | input | TID_W | Thread to retire from |
| squash_valid | input | 1 | Squash request |
| squash_tid | input | TID_W | Thread to squash |
| squash_bound | input | SEQ_W | Entries above this sequence number are flagged |
| done_o | output | NUM_THREADS | 1 when the thread has no walk in progress |
| tail_fix_o | output | NUM_THREADS | Youngest entry flagged this cycle |
| count_o | output | NUM_THREADS*CNT_W | Occupancy per thread |
| head_seq_o | output | NUM_THREADS*SEQ_W | Sequence number of the oldest entry per thread |
| head_squashed_o | output | NUM_THREADS | Squashed flag of the oldest entry |
| head_ready_o | output | NUM_THREADS | Ready flag of the oldest entry |

## Verification
The assertions assume a well-behaved environment. Allocation never targets a full thread. Retirement never targets an empty thread. Neither allocation nor retirement touches a thread that is walking or receiving a request in the same cycle. Sequence numbers within a thread rise from oldest to youngest. The stimulus keeps to these rules by consulting the bench's own model of each thread's occupancy and busy state before driving an operation. It assigns sequence numbers from one increasing counter, and it draws boundaries from just below the most recent numbers so that walks of every length occur.

// File: rtl/rsw_pkg.sv
package rsw_pkg;

  typedef struct packed {
    logic squashed;
    logic ready;
  } rsw_flags_t;

  // index reached by stepping back from idx by steps slots in a ring of depth
  function automatic int ring_back(input int idx, input int steps, input int depth);
    int r;
    r = idx - (steps % depth);
    if (r < 0) r = r + depth;
    return r;
  endfunction

endpackage

// File: rtl/rsw_rst_sync.sv
module rsw_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_out = out_q;

endmodule

// File: rtl/rsw_queue.sv
module rsw_queue #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             alloc_en,
  input  logic [SEQ_W-1:0]                 alloc_seq,
  input  logic                             retire_en,
  input  logic [DEPTH-1:0]                 mark_vec,
  output logic [DEPTH-1:0][SEQ_W-1:0]      seq_all,
  output logic [IDX_W-1:0]                 head_idx,
  output logic [IDX_W-1:0]                 young_idx,
  output logic                             empty,
  output logic                             full,
  output logic [CNT_W-1:0]                 count,
  output logic [SEQ_W-1:0]                 head_seq,
  output rsw_pkg::rsw_flags_t              head_flags
);

  logic [DEPTH-1:0][SEQ_W-1:0]   seq_q;
  rsw_pkg::rsw_flags_t [DEPTH-1:0] flags_q, flags_d;
  logic [IDX_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             alloc_ok, retire_ok;

  function automatic logic [IDX_W-1:0] step_fwd(input logic [IDX_W-1:0] x);
    return (x == IDX_W'(DEPTH-1)) ? '0 : x + 1'b1;
  endfunction

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign alloc_ok  = alloc_en && !full;
  assign retire_ok = retire_en && !empty;

  always_comb begin
    head_d = retire_ok ? step_fwd(head_q) : head_q;
    tail_d = alloc_ok  ? step_fwd(tail_q) : tail_q;
    cnt_d  = cnt_q + CNT_W'(alloc_ok) - CNT_W'(retire_ok);
    for (int i = 0; i < DEPTH; i++) begin
      flags_d[i] = flags_q[i];
      if (mark_vec[i]) begin
        flags_d[i].squashed = 1'b1;
        flags_d[i].ready    = 1'b1;
      end
      if (alloc_ok && (tail_q == IDX_W'(i))) flags_d[i] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
      flags_q <= '0;
    end else begin
      if (retire_ok) head_q <= head_d;
      if (alloc_ok)  tail_q <= tail_d;
      if (alloc_ok || retire_ok) cnt_q <= cnt_d;
      flags_q <= flags_d;
    end
  end

  // payload storage carries no reset
  always_ff @(posedge clk) begin
    if (alloc_ok) seq_q[tail_q] <= alloc_seq;
  end

  assign seq_all    = seq_q;
  assign head_idx   = head_q;
  assign young_idx  = (tail_q == '0) ? IDX_W'(DEPTH-1) : tail_q - 1'b1;
  assign count      = cnt_q;
  assign head_seq   = seq_q[head_q];
  assign head_flags = flags_q[head_q];

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !full);
  assert_retire_nonempty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    retire_en |-> !empty);
  assert_count_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  assert_alloc_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_ok && empty && !retire_en) |=> (head_flags == '0));

endmodule

// File: rtl/rsw_lanes.sv
module rsw_lanes #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int IDX_W = 3,
  parameter int LANES = 2
) (
  input  logic                        active,
  input  logic [IDX_W-1:0]            start_idx,
  input  logic [IDX_W-1:0]            head_idx,
  input  logic [IDX_W-1:0]            young_idx,
  input  logic [SEQ_W-1:0]            bound,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seq_all,
  output logic [DEPTH-1:0]            mark_vec,
  output logic                        finish,
  output logic [IDX_W-1:0]            next_idx,
  output logic                        young_hit
);

  logic             go;
  logic [IDX_W-1:0] lidx;

  // lanes 0..LANES-1 flag entries; lane LANES only looks ahead
  always_comb begin
    mark_vec  = '0;
    finish    = 1'b0;
    next_idx  = start_idx;
    young_hit = 1'b0;
    go        = active;
    lidx      = start_idx;
    for (int k = 0; k <= LANES; k++) begin
      lidx = IDX_W'(rsw_pkg::ring_back(int'(start_idx), k, DEPTH));
      if (go) begin
        if (seq_all[lidx] <= bound) begin
          finish = 1'b1;
          go     = 1'b0;
        end else if (k == LANES) begin
          next_idx = lidx;
          go       = 1'b0;
        end else begin
          mark_vec[lidx] = 1'b1;
          if (lidx == young_idx) young_hit = 1'b1;
          if (lidx == head_idx) begin
            finish = 1'b1;
            go     = 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/rsw_ctrl.sv
module rsw_ctrl #(
  parameter int SEQ_W = 16,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [SEQ_W-1:0] req_bound,
  input  logic             empty,
  input  logic [IDX_W-1:0] young_idx,
  input  logic             finish,
  input  logic [IDX_W-1:0] next_idx,
  output logic             active,
  output logic [IDX_W-1:0] start_idx,
  output logic [SEQ_W-1:0] bound,
  output logic             done
);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [SEQ_W-1:0] bound_q, bound_d;

  always_comb begin
    active    = req ? !empty : busy_q;
    start_idx = req ? young_idx : ptr_q;
    bound     = req ? req_bound : bound_q;
    busy_d    = active && !finish;
    ptr_d     = next_idx;
    bound_d   = bound;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ptr_q   <= '0;
      bound_q <= '0;
    end else begin
      busy_q <= busy_d;
      if (active) begin
        ptr_q   <= ptr_d;
        bound_q <= bound_d;
      end
    end
  end

  assign done = !busy_q;

  assert_empty_req_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req && empty) |=> done);
  assert_req_clears_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !empty && !finish) |=> !done);
  assert_finish_sets_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && finish) |=> done);
  assert_idle_stays_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !req) |=> done);

endmodule

// File: rtl/rob_squash_walker.sv
module rob_squash_walker #(
  parameter int NUM_THREADS = 2,
  parameter int DEPTH       = 8,
  parameter int SEQ_W       = 16,
  parameter int SQ_WIDTH    = 2,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_valid,
  input  logic [TID_W-1:0]             alloc_tid,
  input  logic [SEQ_W-1:0]             alloc_seq,
  input  logic                         retire_valid,
  input  logic [TID_W-1:0]             retire_tid,
  input  logic                         squash_valid,
  input  logic [TID_W-1:0]             squash_tid,
  input  logic [SEQ_W-1:0]             squash_bound,
  output logic [NUM_THREADS-1:0]       done_o,
  output logic [NUM_THREADS-1:0]       tail_fix_o,
  output logic [NUM_THREADS*CNT_W-1:0] count_o,
  output logic [NUM_THREADS*SEQ_W-1:0] head_seq_o,
  output logic [NUM_THREADS-1:0]       head_squashed_o,
  output logic [NUM_THREADS-1:0]       head_ready_o
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic rst_n_s;

  rsw_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
    logic                        req_t, alloc_t, retire_t;
    logic [DEPTH-1:0][SEQ_W-1:0] seq_all;
    logic [IDX_W-1:0]            head_idx, young_idx, start_idx, next_idx;
    logic                        empty, full, active, finish, young_hit, done_t;
    logic [DEPTH-1:0]            mark_vec;
    logic [SEQ_W-1:0]            bound;
    logic [CNT_W-1:0]            cnt_t;
    logic [SEQ_W-1:0]            hseq_t;
    rsw_pkg::rsw_flags_t         hflags_t;

    assign req_t    = squash_valid && (squash_tid == TID_W'(t));
    assign alloc_t  = alloc_valid  && (alloc_tid  == TID_W'(t));
    assign retire_t = retire_valid && (retire_tid == TID_W'(t));

    rsw_queue #(
      .DEPTH(DEPTH), .SEQ_W(SEQ_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_queue (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .alloc_en   (alloc_t),
      .alloc_seq  (alloc_seq),
      .retire_en  (retire_t),
      .mark_vec   (mark_vec),
      .seq_all    (seq_all),
      .head_idx   (head_idx),
      .young_idx  (young_idx),
      .empty      (empty),
      .full       (full),
      .count      (cnt_t),
      .head_seq   (hseq_t),
      .head_flags (hflags_t)
    );

    rsw_ctrl #(
      .SEQ_W(SEQ_W), .IDX_W(IDX_W)
    ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .req       (req_t),
      .req_bound (squash_bound),
      .empty     (empty),
      .young_idx (young_idx),
      .finish    (finish),
      .next_idx  (next_idx),
      .active    (active),
      .start_idx (start_idx),
      .bound     (bound),
      .done      (done_t)
    );

    rsw_lanes #(
      .DEPTH(DEPTH), .SEQ_W(SEQ_W), .IDX_W(IDX_W), .LANES(SQ_WIDTH)
    ) u_lanes (
      .active    (active),
      .start_idx (start_idx),
      .head_idx  (head_idx),
      .young_idx (young_idx),
      .bound     (bound),
      .seq_all   (seq_all),
      .mark_vec  (mark_vec),
      .finish    (finish),
      .next_idx  (next_idx),
      .young_hit (young_hit)
    );

    assign done_o[t]                    = done_t;
    assign tail_fix_o[t]                = young_hit;
    assign count_o[t*CNT_W +: CNT_W]    = cnt_t;
    assign head_seq_o[t*SEQ_W +: SEQ_W] = hseq_t;
    assign head_squashed_o[t]           = hflags_t.squashed;
    assign head_ready_o[t]              = hflags_t.ready;

    assert_width_limit_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
      $countones(mark_vec) <= SQ_WIDTH);
    assert_tail_fix_on_request_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
      young_hit |-> req_t);
    assert_no_touch_busy_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
      (alloc_t || retire_t) |-> (done_t && !req_t));
    assert_marks_only_active_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
      (|mark_vec) |-> (req_t || !done_t));
  end

endmodule

// File: tb/rob_squash_walker_tb.sv
module rob_squash_walker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NT    = 2;
  localparam int DEPTH = 8;
  localparam int SEQ_W = 16;
  localparam int SQW   = 2;
  localparam int TID_W = 1;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic alloc_valid, retire_valid, squash_valid;
  logic [TID_W-1:0] alloc_tid, retire_tid, squash_tid;
  logic [SEQ_W-1:0] alloc_seq, squash_bound;
  logic [NT-1:0] done_o, tail_fix_o, head_squashed_o, head_ready_o;
  logic [NT*CNT_W-1:0] count_o;
  logic [NT*SEQ_W-1:0] head_seq_o;

  int checks = 0;
  int errors = 0;

  // behavioural model of each thread
  int mq_seq[NT][$];
  int mq_sq[NT][$];
  int mq_rdy[NT][$];
  int mbusy[NT];
  int mptr[NT];
  int mbound[NT];
  int seqctr;

  rob_squash_walker #(
    .NUM_THREADS(NT), .DEPTH(DEPTH), .SEQ_W(SEQ_W), .SQ_WIDTH(SQW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_tid(alloc_tid), .alloc_seq(alloc_seq),
    .retire_valid(retire_valid), .retire_tid(retire_tid),
    .squash_valid(squash_valid), .squash_tid(squash_tid), .squash_bound(squash_bound),
    .done_o(done_o), .tail_fix_o(tail_fix_o), .count_o(count_o),
    .head_seq_o(head_seq_o), .head_squashed_o(head_squashed_o), .head_ready_o(head_ready_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int cnt_of(input int t);
    return int'(count_o[t*CNT_W +: CNT_W]);
  endfunction

  function automatic int hseq_of(input int t);
    return int'(head_seq_o[t*SEQ_W +: SEQ_W]);
  endfunction

  task automatic model_step();
    for (int t = 0; t < NT; t++) begin
      int req, sz, act, p, b, fin, tf;
      req = (squash_valid && (int'(squash_tid) == t)) ? 1 : 0;
      sz  = mq_seq[t].size();
      act = req ? (sz > 0) : mbusy[t];
      p   = req ? sz - 1 : mptr[t];
      b   = req ? int'(squash_bound) : mbound[t];
      fin = 0;
      tf  = 0;
      if (act != 0) begin
        for (int k = 0; k <= SQW; k++) begin
          if (mq_seq[t][p] <= b) begin fin = 1; break; end
          if (k == SQW) break;
          mq_sq[t][p]  = 1;
          mq_rdy[t][p] = 1;
          if (p == sz - 1) tf = 1;
          if (p == 0) begin fin = 1; break; end
          p--;
        end
      end
      chk("R7", $sformatf("tail_fix t%0d", t), int'(tail_fix_o[t]), tf);
      mbusy[t] = (act != 0 && fin == 0) ? 1 : 0;
      if (act != 0) begin
        mptr[t]   = p;
        mbound[t] = b;
      end
      if (retire_valid && int'(retire_tid) == t) begin
        void'(mq_seq[t].pop_front());
        void'(mq_sq[t].pop_front());
        void'(mq_rdy[t].pop_front());
      end
      if (alloc_valid && int'(alloc_tid) == t) begin
        mq_seq[t].push_back(int'(alloc_seq));
        mq_sq[t].push_back(0);
        mq_rdy[t].push_back(0);
      end
    end
  endtask

  task automatic compare_state();
    for (int t = 0; t < NT; t++) begin
      chk("R6", $sformatf("done t%0d", t), int'(done_o[t]), mbusy[t] ? 0 : 1);
      chk("R11", $sformatf("count t%0d", t), cnt_of(t), mq_seq[t].size());
      if (mq_seq[t].size() > 0) begin
        chk("R11", $sformatf("head seq t%0d", t), hseq_of(t), mq_seq[t][0]);
        chk("R4", $sformatf("head squashed t%0d", t), int'(head_squashed_o[t]), mq_sq[t][0]);
        chk("R4", $sformatf("head ready t%0d", t), int'(head_ready_o[t]), mq_rdy[t][0]);
      end
    end
  endtask

  // called at a negative edge: drive, predict, clock, then compare
  task automatic do_cycle(input bit av, input int at, input int as,
                          input bit rv, input int rt,
                          input bit sv, input int st, input int sb);
    alloc_valid  = av;  alloc_tid  = TID_W'(at); alloc_seq    = SEQ_W'(as);
    retire_valid = rv;  retire_tid = TID_W'(rt);
    squash_valid = sv;  squash_tid = TID_W'(st); squash_bound = SEQ_W'(sb);
    #1;
    model_step();
    @(posedge clk);
    @(negedge clk);
    alloc_valid = 1'b0; retire_valid = 1'b0; squash_valid = 1'b0;
    compare_state();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) do_cycle(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(input int t, input int first, input int n);
    for (int i = 0; i < n; i++) do_cycle(1, t, first + i, 0, 0, 0, 0, 0);
  endtask

  // retire everything from a thread and return how many were flagged
  task automatic drain(input int t, output int flagged);
    flagged = 0;
    while (mq_seq[t].size() > 0) begin
      flagged += int'(head_squashed_o[t]);
      do_cycle(0, 0, 0, 1, t, 0, 0, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int flagged;
    rst_n = 1'b0;
    alloc_valid = 1'b0; retire_valid = 1'b0; squash_valid = 1'b0;
    alloc_tid = '0; retire_tid = '0; squash_tid = '0;
    alloc_seq = '0; squash_bound = '0;
    for (int t = 0; t < NT; t++) begin
      mbusy[t] = 0; mptr[t] = 0; mbound[t] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state
    chk("R10", "done after reset", int'(done_o), 3);
    chk("R10", "tail_fix after reset", int'(tail_fix_o), 0);
    chk("R10", "count t0 after reset", cnt_of(0), 0);
    chk("R10", "count t1 after reset", cnt_of(1), 0);

    // boundary stop: 10..16, bound 12 -> 16,15 then 14,13, stop at 12
    fill(0, 10, 7);
    do_cycle(0, 0, 0, 0, 0, 1, 0, 12);
    chk("R2", "done t0 after first squash cycle", int'(done_o[0]), 0);
    do_cycle(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R6", "done t0 after boundary reached", int'(done_o[0]), 1);
    for (int i = 0; i < 7; i++) begin
      chk("R4", $sformatf("flag of seq %0d", 10 + i), int'(head_squashed_o[0]), (10 + i > 12) ? 1 : 0);
      chk("R4", $sformatf("ready of seq %0d", 10 + i), int'(head_ready_o[0]), (10 + i > 12) ? 1 : 0);
      do_cycle(0, 0, 0, 1, 0, 0, 0, 0);
    end

    // head stop: 20..23, bound 5 -> walk ends after flagging 20
    fill(1, 20, 4);
    do_cycle(0, 0, 0, 0, 0, 1, 1, 5);
    chk("R5", "done t1 mid walk", int'(done_o[1]), 0);
    do_cycle(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R5", "done t1 after head flagged", int'(done_o[1]), 1);
    drain(1, flagged);
    chk("R5", "entries flagged down to head", flagged, 4);

    // empty thread request
    do_cycle(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R1", "done t0 after empty request", int'(done_o[0]), 1);
    chk("R1", "count t0 still empty", cnt_of(0), 0);

    // restart: 30..37 bound 30, then restart with bound 35
    fill(0, 30, 8);
    do_cycle(0, 0, 0, 0, 0, 1, 0, 30);
    chk("R2", "done t0 walking", int'(done_o[0]), 0);
    do_cycle(0, 0, 0, 0, 0, 1, 0, 35);
    chk("R8", "done t0 after restart finished", int'(done_o[0]), 1);
    idle(2);
    drain(0, flagged);
    chk("R8", "entries flagged after restart", flagged, 2);

    // overlap: t0 40..45 bound 39, t1 50..55 bound 52 one cycle later
    fill(0, 40, 6);
    fill(1, 50, 6);
    do_cycle(0, 0, 0, 0, 0, 1, 0, 39);
    chk("R9", "t0 walking t1 idle", int'(done_o), 2);
    do_cycle(0, 0, 0, 0, 0, 1, 1, 52);
    chk("R9", "both threads walking", int'(done_o), 0);
    do_cycle(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R9", "both threads finished", int'(done_o), 3);
    drain(0, flagged);
    chk("R9", "t0 flagged count", flagged, 6);
    drain(1, flagged);
    chk("R9", "t1 flagged count", flagged, 3);

    // random traffic within the input rules, compared every cycle
    seqctr = 100;
    for (int n = 0; n < 3000; n++) begin
      bit sv, av, rv;
      int st, sb, at, rt;
      sv = ($urandom % 6) == 0;
      st = $urandom % NT;
      sb = seqctr - int'($urandom % 12);
      if (sb < 0) sb = 0;
      at = $urandom % NT;
      av = (($urandom % 2) == 0) && (mbusy[at] == 0) && !(sv && st == at)
           && (mq_seq[at].size() < DEPTH);
      rt = $urandom % NT;
      rv = (($urandom % 3) == 0) && (mbusy[rt] == 0) && !(sv && st == rt)
           && (mq_seq[rt].size() > 0);
      do_cycle(av, at, seqctr, rv, rt, sv, st, sb);
      if (av) seqctr++;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule